// File: doc/BRIEF.md
# Serial Port Control and Interrupt Register Block

This block is the software-visible face of a serial port. It decodes single-word reads and writes at fixed byte offsets. It holds the mode and baud configuration words, the interrupt mask and the channel status flags, and it drives one level-sensitive interrupt line. Writes to the command word become one-cycle strobes toward the receive and transmit engines. The engines report their events back on plain one-cycle strobe inputs.

The interrupt mask is never written directly. A write of ones to the enable word sets mask bits, and a write of ones to the disable word clears them. A keyed protection word can lock the configuration words against stray writes. Every attempt that is refused leaves a sticky flag, which software reads and clears.

Top module: `serial_ctrl_regs`

## Requirements
- R1: After reset the mask reads 0, protection is off, the mode and baud words read 0, `irq` is low, and status (offset 0x14) reads 0x202 while `txIdle` is high: bit 1 transmit-ready and bit 9 transmitter-empty are set.
- R2: A write to offset 0x00 gives, in the cycle after the write edge, a one-cycle pulse for each set bit: bit 2 `rxRstPulse`, bit 3 `txRstPulse`, bit 4 `rxEnPulse`, bit 5 `rxDisPulse`, bit 6 `txEnPulse`, bit 7 `txDisPulse`. Offset 0x00 reads as 0.
- R3: When the enable and disable bits of one direction are written together, only the disable pulse is produced.
- R4: A write of ones to offset 0x08 sets those mask bits and a write of ones to 0x0C clears them. Only status positions 0, 1, 2, 5, 7 and 9 are kept. The mask reads back at 0x10.
- R5: `irq` is high exactly when some bit is set in both the mask and the status word.
- R6: A received byte sets status bit 0 and is read at 0x18. That read clears bit 0. A byte that arrives while bit 0 is still set, with no read in the same cycle, sets overrun bit 5 and replaces the held byte.
- R7: A break strobe sets bit 2 and a parity strobe sets bit 7. These flags and overrun stay set until a write of bit 8 to offset 0x00, which clears bits 2, 5 and 7 and leaves bit 0 as it was.
- R8: A write to 0x1C puts the low byte on `txData` with a one-cycle `txLoad` and clears bit 1 until `txTaken`. Bit 9 reads as bit 1 AND `txIdle`.
- R9: A write to 0xE4 takes effect only when bits 31:8 equal 0x555341. Bit 0 then switches protection on (1) or off (0). Offset 0xE4 reads as the key in bits 31:8 and the protection state in bit 0.
- R10: While protection is on, writes to mode (0x04) and baud (0x20) are dropped and set bit 0 of 0xE8. Reading 0xE8 returns the flag and clears it.
- R11: Offset 0xFC reads as the constant `VERSION` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe; read side effects occur at its clock edge |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational while rdEn is high |
| irq | output | 1 | Interrupt request level |
| rxByteValid | input | 1 | Receive engine delivers a byte |
| rxByte | input | DATA_W | Received byte |
| rxBreak | input | 1 | Receive engine saw a break |
| rxParityErr | input | 1 | Receive engine saw a parity error |
| txTaken | input | 1 | Transmit engine consumed the held byte |
| txIdle | input | 1 | Transmit shifter is idle |
| txData | output | DATA_W | Byte for the transmit engine |
| txLoad | output | 1 | One-cycle pulse: txData is new |
| rxRstPulse | output | 1 | Receiver reset pulse |
| txRstPulse | output | 1 | Transmitter reset pulse |
| rxEnPulse | output | 1 | Receiver enable pulse |
| rxDisPulse | output | 1 | Receiver disable pulse |
| txEnPulse | output | 1 | Transmitter enable pulse |
| txDisPulse | output | 1 | Transmitter disable pulse |
| modeCfg | output | 32 | Mode configuration word |
| baudCfg | output | 32 | Baud configuration word |

## Verification
The bench sweeps all 512 values of the low nine command bits. A decoder that lets enable win over disable, or that stretches a pulse, fails there. It then drives a run of set and clear patterns through the enable and disable words against an arithmetic mask model, which catches unused bits being stored and the set and clear being swapped. With the status both full and partly cleared, it walks a single mask bit over all ten positions, so a wrong interrupt term shows up at the position it belongs to. It also checks the arrival of a second byte without a read, the clear of the sticky flags that must spare receive-ready, a lock under a wrong key, and the violation flag that must clear on its own read.

// File: rtl/serial_regs_pkg.sv
package serial_regs_pkg;
  localparam logic [7:0] OFF_CMD    = 8'h00;
  localparam logic [7:0] OFF_MODE   = 8'h04;
  localparam logic [7:0] OFF_IEN    = 8'h08;
  localparam logic [7:0] OFF_IDIS   = 8'h0C;
  localparam logic [7:0] OFF_IMASK  = 8'h10;
  localparam logic [7:0] OFF_STAT   = 8'h14;
  localparam logic [7:0] OFF_RHOLD  = 8'h18;
  localparam logic [7:0] OFF_THOLD  = 8'h1C;
  localparam logic [7:0] OFF_BAUD   = 8'h20;
  localparam logic [7:0] OFF_WPMODE = 8'hE4;
  localparam logic [7:0] OFF_WPSTAT = 8'hE8;
  localparam logic [7:0] OFF_VER    = 8'hFC;

  localparam int ST_W       = 10;
  localparam int ST_RXRDY   = 0;
  localparam int ST_TXRDY   = 1;
  localparam int ST_BRK     = 2;
  localparam int ST_OVR     = 5;
  localparam int ST_PAR     = 7;
  localparam int ST_TXEMPTY = 9;
  localparam logic [ST_W-1:0] ST_USED = 10'h2A7;

  typedef struct packed {
    logic rxRst;
    logic txRst;
    logic rxEn;
    logic rxDis;
    logic txEn;
    logic txDis;
  } cmdPulses_t;

  typedef struct packed {
    logic wrMode;
    logic wrBaud;
    logic wrIen;
    logic wrIdis;
    logic wrThold;
    logic rdRhold;
    logic clrSta;
    logic rxRstNow;
    logic txRstNow;
  } regStrobes_t;
endpackage

// File: rtl/serial_regs_ctrl.sv
module serial_regs_ctrl
  import serial_regs_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter logic [23:0] WP_KEY = 24'h555341
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [8:2]        cmdBits,
  input  logic [23:0]       keyField,
  input  logic              protectBit,
  output regStrobes_t       strb,
  output cmdPulses_t        cmdPulse,
  output logic              wpOn,
  output logic              wpViolation
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
    return a == ADDR_W'(off);
  endfunction

  logic isCmd, cfgTry, wpWrite, rdWpStat;

  always_comb begin
    isCmd         = wrEn && hit(addr, OFF_CMD);
    cfgTry        = wrEn && (hit(addr, OFF_MODE) || hit(addr, OFF_BAUD));
    wpWrite       = wrEn && hit(addr, OFF_WPMODE) && (keyField == WP_KEY);
    rdWpStat      = rdEn && hit(addr, OFF_WPSTAT);
    strb.wrMode   = wrEn && hit(addr, OFF_MODE) && !wpOn;
    strb.wrBaud   = wrEn && hit(addr, OFF_BAUD) && !wpOn;
    strb.wrIen    = wrEn && hit(addr, OFF_IEN);
    strb.wrIdis   = wrEn && hit(addr, OFF_IDIS);
    strb.wrThold  = wrEn && hit(addr, OFF_THOLD);
    strb.rdRhold  = rdEn && hit(addr, OFF_RHOLD);
    strb.clrSta   = isCmd && cmdBits[8];
    strb.rxRstNow = isCmd && cmdBits[2];
    strb.txRstNow = isCmd && cmdBits[3];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdPulse    <= '0;
      wpOn        <= 1'b0;
      wpViolation <= 1'b0;
    end else begin
      cmdPulse.rxRst <= isCmd && cmdBits[2];
      cmdPulse.txRst <= isCmd && cmdBits[3];
      cmdPulse.rxEn  <= isCmd && cmdBits[4] && !cmdBits[5];
      cmdPulse.rxDis <= isCmd && cmdBits[5];
      cmdPulse.txEn  <= isCmd && cmdBits[6] && !cmdBits[7];
      cmdPulse.txDis <= isCmd && cmdBits[7];
      if (wpWrite) wpOn <= protectBit;
      if (cfgTry && wpOn) wpViolation <= 1'b1;
      else if (rdWpStat)  wpViolation <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_regs_datapath.sv
module serial_regs_datapath
  import serial_regs_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 8,
  parameter logic [23:0] WP_KEY  = 24'h555341,
  parameter logic [31:0] VERSION = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strb,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              wpOn,
  input  logic              wpViolation,
  input  logic              rxByteValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxBreak,
  input  logic              rxParityErr,
  input  logic              txTaken,
  input  logic              txIdle,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic [31:0]       modeCfg,
  output logic [31:0]       baudCfg,
  output logic [DATA_W-1:0] txData,
  output logic              txLoad,
  output logic [ST_W-1:0]   statusBits,
  output logic [ST_W-1:0]   maskBits
);
  logic              rxRdy, txRdy, brkFlag, ovrFlag, parFlag;
  logic [DATA_W-1:0] rxHold;
  logic [ST_W-1:0]   wrBits;

  assign wrBits = wdata[ST_W-1:0] & ST_USED;

  always_comb begin
    statusBits             = '0;
    statusBits[ST_RXRDY]   = rxRdy;
    statusBits[ST_TXRDY]   = txRdy;
    statusBits[ST_BRK]     = brkFlag;
    statusBits[ST_OVR]     = ovrFlag;
    statusBits[ST_PAR]     = parFlag;
    statusBits[ST_TXEMPTY] = txRdy && txIdle;
  end

  assign irq = |(maskBits & statusBits);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxRdy    <= 1'b0;
      txRdy    <= 1'b1;
      brkFlag  <= 1'b0;
      ovrFlag  <= 1'b0;
      parFlag  <= 1'b0;
      rxHold   <= '0;
      maskBits <= '0;
      modeCfg  <= '0;
      baudCfg  <= '0;
      txData   <= '0;
      txLoad   <= 1'b0;
    end else begin
      if (strb.clrSta) begin
        brkFlag <= 1'b0;
        ovrFlag <= 1'b0;
        parFlag <= 1'b0;
      end
      if (rxBreak)     brkFlag <= 1'b1;
      if (rxParityErr) parFlag <= 1'b1;

      if (strb.rxRstNow) rxRdy <= 1'b0;
      else if (rxByteValid) begin
        rxRdy  <= 1'b1;
        rxHold <= rxByte;
        if (rxRdy && !strb.rdRhold) ovrFlag <= 1'b1;
      end else if (strb.rdRhold) rxRdy <= 1'b0;

      if (strb.txRstNow)     txRdy <= 1'b1;
      else if (strb.wrThold) txRdy <= 1'b0;
      else if (txTaken)      txRdy <= 1'b1;

      txLoad <= strb.wrThold;
      if (strb.wrThold) txData <= wdata[DATA_W-1:0];

      if (strb.wrIen)       maskBits <= maskBits | wrBits;
      else if (strb.wrIdis) maskBits <= maskBits & ~wrBits;

      if (strb.wrMode) modeCfg <= wdata;
      if (strb.wrBaud) baudCfg <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rdEn) begin
      case (addr)
        ADDR_W'(OFF_MODE):   rdata = modeCfg;
        ADDR_W'(OFF_IMASK):  rdata = 32'(maskBits);
        ADDR_W'(OFF_STAT):   rdata = 32'(statusBits);
        ADDR_W'(OFF_RHOLD):  rdata = 32'(rxHold);
        ADDR_W'(OFF_BAUD):   rdata = baudCfg;
        ADDR_W'(OFF_WPMODE): rdata = {WP_KEY, 7'b0, wpOn};
        ADDR_W'(OFF_WPSTAT): rdata = {31'b0, wpViolation};
        ADDR_W'(OFF_VER):    rdata = VERSION;
        default:             rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/serial_ctrl_regs.sv
module serial_ctrl_regs
  import serial_regs_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 8,
  parameter logic [23:0] WP_KEY  = 24'h555341,
  parameter logic [31:0] VERSION = 32'h0001_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  input  logic              rxByteValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              rxBreak,
  input  logic              rxParityErr,
  input  logic              txTaken,
  input  logic              txIdle,
  output logic [DATA_W-1:0] txData,
  output logic              txLoad,
  output logic              rxRstPulse,
  output logic              txRstPulse,
  output logic              rxEnPulse,
  output logic              rxDisPulse,
  output logic              txEnPulse,
  output logic              txDisPulse,
  output logic [31:0]       modeCfg,
  output logic [31:0]       baudCfg
);
  regStrobes_t     strb;
  cmdPulses_t      cmdPulse;
  logic            wpOn, wpViolation;
  logic [ST_W-1:0] statusBits, maskBits;

  serial_regs_ctrl #(.ADDR_W(ADDR_W), .WP_KEY(WP_KEY)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .cmdBits(wdata[8:2]), .keyField(wdata[31:8]), .protectBit(wdata[0]),
    .strb(strb), .cmdPulse(cmdPulse), .wpOn(wpOn), .wpViolation(wpViolation)
  );

  serial_regs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WP_KEY(WP_KEY), .VERSION(VERSION)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .wpOn(wpOn), .wpViolation(wpViolation),
    .rxByteValid(rxByteValid), .rxByte(rxByte), .rxBreak(rxBreak), .rxParityErr(rxParityErr),
    .txTaken(txTaken), .txIdle(txIdle), .rdata(rdata), .irq(irq),
    .modeCfg(modeCfg), .baudCfg(baudCfg), .txData(txData), .txLoad(txLoad),
    .statusBits(statusBits), .maskBits(maskBits)
  );

  assign rxRstPulse = cmdPulse.rxRst;
  assign txRstPulse = cmdPulse.txRst;
  assign rxEnPulse  = cmdPulse.rxEn;
  assign rxDisPulse = cmdPulse.rxDis;
  assign txEnPulse  = cmdPulse.txEn;
  assign txDisPulse = cmdPulse.txDis;
endmodule

// File: rtl/serial_regs_chk.sv
module serial_regs_chk
  import serial_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              rxRstPulse,
  input logic              rxEnPulse,
  input logic              rxDisPulse,
  input logic              txEnPulse,
  input logic              txDisPulse,
  input logic              irq,
  input logic [ST_W-1:0]   maskBits,
  input logic [ST_W-1:0]   statusBits,
  input logic              wpOn,
  input logic [31:0]       modeCfg,
  input logic [31:0]       baudCfg
);
  AST_RXRST_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    rxRstPulse |-> $past(wrEn && addr == ADDR_W'(OFF_CMD) && wdata[2])); // R2
  AST_RX_EN_DIS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(rxEnPulse && rxDisPulse)); // R3
  AST_TX_EN_DIS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(txEnPulse && txDisPulse)); // R3
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (maskBits != '0)); // R5
  AST_THOLD_CLEARS_READY: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn && addr == ADDR_W'(OFF_THOLD)) |-> !statusBits[ST_TXRDY]); // R8
  AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    $past(wpOn) |-> $stable(modeCfg)); // R10
  AST_BAUD_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    $past(wpOn) |-> $stable(baudCfg)); // R10
endmodule

bind serial_ctrl_regs serial_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
  .rxRstPulse(rxRstPulse), .rxEnPulse(rxEnPulse), .rxDisPulse(rxDisPulse),
  .txEnPulse(txEnPulse), .txDisPulse(txDisPulse), .irq(irq),
  .maskBits(maskBits), .statusBits(statusBits), .wpOn(wpOn),
  .modeCfg(modeCfg), .baudCfg(baudCfg)
);

// File: tb/test_serial_ctrl_regs.sv
module test_serial_ctrl_regs;
  localparam logic [31:0] VER   = 32'h0001_0000;
  localparam logic [23:0] KEY   = 24'h555341;
  localparam logic [9:0]  USED  = 10'h2A7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        rxByteValid = 1'b0, rxBreak = 1'b0, rxParityErr = 1'b0, txTaken = 1'b0, txIdle = 1'b1;
  logic [7:0]  rxByte = '0;
  logic [7:0]  txData;
  logic        txLoad, rxRstPulse, txRstPulse, rxEnPulse, rxDisPulse, txEnPulse, txDisPulse;
  logic [31:0] modeCfg, baudCfg;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  serial_ctrl_regs i_serial_ctrl_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .rxByteValid(rxByteValid), .rxByte(rxByte),
    .rxBreak(rxBreak), .rxParityErr(rxParityErr), .txTaken(txTaken), .txIdle(txIdle),
    .txData(txData), .txLoad(txLoad), .rxRstPulse(rxRstPulse), .txRstPulse(txRstPulse),
    .rxEnPulse(rxEnPulse), .rxDisPulse(rxDisPulse), .txEnPulse(txEnPulse),
    .txDisPulse(txDisPulse), .modeCfg(modeCfg), .baudCfg(baudCfg)
  );

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rdEn = 1'b1; addr = a;
    #2 d = rdata;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic rxPush(input logic [7:0] b);
    @(negedge clk); rxByteValid = 1'b1; rxByte = b;
    @(negedge clk); rxByteValid = 1'b0;
  endtask

  function automatic logic [5:0] pulseVec();
    return {rxRstPulse, txRstPulse, rxEnPulse, rxDisPulse, txEnPulse, txDisPulse};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [9:0]  m;
    logic [9:0]  st;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h14, v); checkEq("R1 status", v, 32'h202);
    rd(8'h10, v); checkEq("R1 mask", v, 0);
    rd(8'h04, v); checkEq("R1 mode", v, 0);
    rd(8'h20, v); checkEq("R1 baud", v, 0);
    rd(8'hE4, v); checkEq("R1 wp", v, {KEY, 8'h00});
    checkEq("R1 irq", 32'(irq), 0);
    rd(8'hFC, v); checkEq("R11 version", v, VER);

    // R4 mask set and clear sweep
    m = '0;
    for (int i = 0; i < 32; i++) begin
      logic [31:0] ie, id;
      ie = 32'(i) * 32'h9E37_79B1;
      id = (32'(i) * 32'h7F4A_7C15) >> 3;
      wr(8'h08, ie); m = m | (ie[9:0] & USED);
      wr(8'h0C, id); m = m & ~(id[9:0] & USED);
      rd(8'h10, v); checkEq("R4 mask", v, 32'(m));
    end
    wr(8'h0C, 32'hFFFF_FFFF);

    // R2 R3 command sweep
    for (int c = 0; c < 512; c++) begin
      logic [8:0] b;
      logic [5:0] exp;
      b = 9'(c);
      exp = {b[2], b[3], b[4] & ~b[5], b[5], b[6] & ~b[7], b[7]};
      wr(8'h00, 32'(b));
      checkEq("R2 R3 pulses", 32'(pulseVec()), 32'(exp));
      @(negedge clk);
      checkEq("R2 pulse width", 32'(pulseVec()), 0);
    end
    rd(8'h00, v); checkEq("R2 cmd readback", v, 0);

    // R6 receive path and overrun
    rxPush(8'h5A);
    rd(8'h14, v); checkEq("R6 rx ready", v & 32'h21, 32'h01);
    rd(8'h18, v); checkEq("R6 rx byte", v, 32'h5A);
    rd(8'h14, v); checkEq("R6 ready cleared", v & 32'h21, 32'h00);
    rxPush(8'h11);
    rxPush(8'h22);
    rd(8'h14, v); checkEq("R6 overrun", v & 32'h21, 32'h21);
    rd(8'h18, v); checkEq("R6 second byte", v, 32'h22);

    // R7 sticky flags and clear
    rxPush(8'h33);
    @(negedge clk); rxBreak = 1'b1; @(negedge clk); rxBreak = 1'b0;
    @(negedge clk); rxParityErr = 1'b1; @(negedge clk); rxParityErr = 1'b0;
    rd(8'h14, v); checkEq("R7 all flags", v, 32'h2A7);

    // R5 irq sweep with full status
    st = 10'h2A7;
    for (int b = 0; b < 10; b++) begin
      wr(8'h0C, 32'h3FF); wr(8'h08, 32'(1) << b);
      checkEq("R5 irq full", 32'(irq), 32'(st[b]));
    end
    wr(8'h00, 32'h100);
    rd(8'h14, v); checkEq("R7 cleared", v, 32'h203);
    st = 10'h203;
    for (int b = 0; b < 10; b++) begin
      wr(8'h0C, 32'h3FF); wr(8'h08, 32'(1) << b);
      checkEq("R5 irq partial", 32'(irq), 32'(st[b]));
    end
    wr(8'h0C, 32'h3FF);

    // R8 transmit holding
    wr(8'h1C, 32'h1C3);
    checkEq("R8 txLoad", 32'(txLoad), 1);
    checkEq("R8 txData", 32'(txData), 32'hC3);
    @(negedge clk);
    checkEq("R8 txLoad width", 32'(txLoad), 0);
    rd(8'h14, v); checkEq("R8 not ready", v & 32'h202, 32'h000);
    @(negedge clk); txTaken = 1'b1; @(negedge clk); txTaken = 1'b0;
    rd(8'h14, v); checkEq("R8 ready again", v & 32'h202, 32'h202);
    txIdle = 1'b0;
    rd(8'h14, v); checkEq("R8 busy not empty", v & 32'h202, 32'h002);
    txIdle = 1'b1;

    // R9 R10 write protection
    wr(8'h04, 32'h123);
    rd(8'h04, v); checkEq("R9 mode open", v, 32'h123);
    wr(8'hE4, {24'h555340, 8'h01});
    wr(8'h04, 32'h200);
    rd(8'h04, v); checkEq("R9 wrong key", v, 32'h200);
    wr(8'hE4, {KEY, 8'h01});
    rd(8'hE4, v); checkEq("R9 locked", v, {KEY, 8'h01});
    wr(8'h04, 32'h456);
    wr(8'h20, 32'h99);
    rd(8'h04, v); checkEq("R10 mode kept", v, 32'h200);
    checkEq("R10 mode port", modeCfg, 32'h200);
    rd(8'h20, v); checkEq("R10 baud kept", v, 0);
    rd(8'hE8, v); checkEq("R10 violation", v, 1);
    rd(8'hE8, v); checkEq("R10 violation cleared", v, 0);
    wr(8'hE4, {KEY, 8'h00});
    wr(8'h20, 32'h99);
    rd(8'h20, v); checkEq("R9 unlocked", v, 32'h99);
    checkEq("R9 baud port", baudCfg, 32'h99);
    rd(8'hE8, v); checkEq("R10 no violation", v, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule